// File: doc/BRIEF.md
# Per-Pin Input Deglitch Filter

This block cleans up five general-purpose input pins before the rest of the chip sees them. Every pin first passes through a two-flop synchronizer. After that, each pin has its own filter channel. Software turns a channel on or off by writing one bit of a configuration register, which sits on a simple byte-wide register bus.

When a channel is off, the synchronized level goes straight to the filtered output. When a channel is on, a new level reaches the output only after it has been seen on three consecutive ticks of a shared sampling enable. A shorter pulse is rejected as noise. The sampling tick is generated outside the block.

A stop-mode input suspends all filtering while it is high. The configuration register keeps its contents during stop mode, so the stored settings take effect again as soon as stop mode ends.

Top module: `port_deglitch`

## Requirements
- R1: After reset the configuration register reads 0x00, and every filtered output follows its synchronized pin.
- R2: A write to address 0xD7 stores data bits 4..0 as the channel enables, with bit n controlling pin n and 1 meaning filtering on. A read at 0xD7 returns the stored bits in the same positions.
- R3: Bits 7..5 of the configuration register always read as 0, and writing them has no effect.
- R4: A write to any address other than 0xD7 leaves the register unchanged, and a read at any other address returns 0x00.
- R5: On a disabled channel, the filtered output takes the synchronized pin value on every clock. A pin change driven before clock edge k appears at the output after edge k+2.
- R6: On an enabled channel, a level that differs from the output and is sampled on three consecutive ticks becomes the new output at the clock edge of the third tick.
- R7: On an enabled channel, a differing level seen on fewer than three consecutive ticks is rejected. Once the input matches the output again, the consecutive count starts over.
- R8: On an enabled channel, the filtered output never changes on a clock without a sampling tick.
- R9: While stop mode is high, every channel acts as disabled, whatever the register holds.
- R10: When stop mode falls, filtering resumes with the unchanged stored enables.
- R11: Channels are independent. Filtering on one pin does not delay or alter the output of another pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Register bus address |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Register read data (combinational) |
| stopMode | input | 1 | Low-power stop mode, suspends filtering while high |
| sampleTick | input | 1 | One-clock sampling enable for the filters |
| pinIn | input | 5 | Raw, asynchronous pin levels |
| pinOut | output | 5 | Filtered pin levels |

## Verification
Some rules hold on every single cycle, and the assertions check those:
- a disabled or stopped channel copies its synchronized input;
- an enabled channel is frozen on clocks without a tick;
- a tick on a channel whose input already matches its output changes nothing;
- the unused register bits read as zero.

Other behaviour depends on history and only the bench's directed scenarios can show it. This covers the three-tick acceptance count, the count restarting after a two-tick glitch, the stored enables coming back after stop mode, and the register decode across addresses.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic sampleStrobe;  // sampling tick qualified by stop mode
    logic bypassAll;     // force every channel to pass-through
  } deglitch_strobe_t;

endpackage

// File: rtl/deglitch_ctrl.sv
module deglitch_ctrl
  import deglitch_pkg::*;
#(
  parameter int NUM_PINS = 5,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'hD7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic                stopMode,
  input  logic                sampleTick,
  output logic [NUM_PINS-1:0] cfgEnable,
  output deglitch_strobe_t    strobes
);

  localparam int PAD_W = DATA_W - NUM_PINS;

  logic addrHit;
  logic [NUM_PINS-1:0] cfgReg;

  assign addrHit = (busAddr == CFG_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (busWrEn && addrHit) begin
      cfgReg <= busWrData[NUM_PINS-1:0];
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign busRdData = addrHit ? {{PAD_W{1'b0}}, cfgReg} : '0;
    end else begin : g_nopad
      assign busRdData = addrHit ? cfgReg[DATA_W-1:0] : '0;
    end
  endgenerate

  assign cfgEnable             = cfgReg;
  assign strobes.bypassAll     = stopMode;
  assign strobes.sampleStrobe  = sampleTick & ~stopMode;

endmodule

// File: rtl/deglitch_channel.sv
module deglitch_channel #(
  parameter int SYNC_STAGES  = 2,
  parameter int STABLE_COUNT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic filterOn,
  input  logic sampleStrobe,
  output logic syncOut,
  output logic filtOut
);

  localparam int CNT_W = (STABLE_COUNT > 2) ? $clog2(STABLE_COUNT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_COUNT - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [CNT_W-1:0]       diffCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], rawIn};
    end
  end

  assign syncOut = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtOut   <= 1'b0;
      diffCount <= '0;
    end else if (!filterOn) begin
      filtOut   <= syncOut;
      diffCount <= '0;
    end else if (syncOut == filtOut) begin
      diffCount <= '0;
    end else if (sampleStrobe) begin
      if (diffCount == CNT_LAST) begin
        filtOut   <= syncOut;
        diffCount <= '0;
      end else begin
        diffCount <= diffCount + 1'b1;
      end
    end
  end

endmodule

// File: rtl/deglitch_datapath.sv
module deglitch_datapath
  import deglitch_pkg::*;
#(
  parameter int NUM_PINS     = 5,
  parameter int SYNC_STAGES  = 2,
  parameter int STABLE_COUNT = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] cfgEnable,
  input  deglitch_strobe_t    strobes,
  output logic [NUM_PINS-1:0] syncPins,
  output logic [NUM_PINS-1:0] pinOut
);

  logic [NUM_PINS-1:0] filterOn;

  assign filterOn = cfgEnable & {NUM_PINS{~strobes.bypassAll}};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chan
    deglitch_channel #(
      .SYNC_STAGES (SYNC_STAGES),
      .STABLE_COUNT(STABLE_COUNT)
    ) u_chan (
      .clk         (clk),
      .rstN        (rstN),
      .rawIn       (pinIn[i]),
      .filterOn    (filterOn[i]),
      .sampleStrobe(strobes.sampleStrobe),
      .syncOut     (syncPins[i]),
      .filtOut     (pinOut[i])
    );
  end

endmodule

// File: rtl/port_deglitch.sv
module port_deglitch
  import deglitch_pkg::*;
#(
  parameter int NUM_PINS     = 5,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int STABLE_COUNT = 3,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'hD7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic                stopMode,
  input  logic                sampleTick,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut
);

  logic [NUM_PINS-1:0] cfgEnable;
  logic [NUM_PINS-1:0] syncPins;
  deglitch_strobe_t    strobes;

  deglitch_ctrl #(
    .NUM_PINS(NUM_PINS),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CFG_ADDR(CFG_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .stopMode  (stopMode),
    .sampleTick(sampleTick),
    .cfgEnable (cfgEnable),
    .strobes   (strobes)
  );

  deglitch_datapath #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES),
    .STABLE_COUNT(STABLE_COUNT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .cfgEnable(cfgEnable),
    .strobes  (strobes),
    .syncPins (syncPins),
    .pinOut   (pinOut)
  );

endmodule

// File: rtl/port_deglitch_checker.sv
module port_deglitch_checker #(
  parameter int NUM_PINS = 5,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'hD7
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busRdData,
  input logic                stopMode,
  input logic                sampleTick,
  input logic [NUM_PINS-1:0] cfgEnable,
  input logic [NUM_PINS-1:0] syncPins,
  input logic [NUM_PINS-1:0] pinOut
);

  // R3: unused register bits never read as one
  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[DATA_W-1:NUM_PINS] == '0);

  // R4: foreign addresses read zero
  assert_foreign_read_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != CFG_ADDR) |-> (busRdData == '0));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    // R5 and R9: a disabled or stopped channel copies its synchronized input
    assert_passthru_R5_R9: assert property (@(posedge clk) disable iff (!rstN)
      (!cfgEnable[i] || stopMode) |=> (pinOut[i] == $past(syncPins[i])));

    // R8: an active filter holds its output on clocks without a tick
    assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
      (cfgEnable[i] && !stopMode && !sampleTick) |=> $stable(pinOut[i]));

    // R7: a tick with a matching input changes nothing
    assert_match_no_change_R7: assert property (@(posedge clk) disable iff (!rstN)
      (cfgEnable[i] && !stopMode && (syncPins[i] == pinOut[i])) |=> $stable(pinOut[i]));
  end

endmodule

bind port_deglitch port_deglitch_checker #(
  .NUM_PINS(NUM_PINS),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .CFG_ADDR(CFG_ADDR)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRdData (busRdData),
  .stopMode  (stopMode),
  .sampleTick(sampleTick),
  .cfgEnable (cfgEnable),
  .syncPins  (syncPins),
  .pinOut    (pinOut)
);

// File: tb/port_deglitch_bench.sv
`timescale 1ns/1ps
module port_deglitch_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       stopMode = 1'b0;
  logic       sampleTick = 1'b0;
  logic [4:0] pinIn = 5'b0;
  logic [4:0] pinOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  port_deglitch u_port_deglitch (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .stopMode(stopMode),
    .sampleTick(sampleTick), .pinIn(pinIn), .pinOut(pinOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 8'h00;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
    busAddr = 8'h00;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) sampleTick = 1'b1;
    @(negedge clk) sampleTick = 1'b0;
  endtask

  task automatic clearAll();
    busWrite(8'hD7, 8'h00);
    pinIn = 5'b0;
    settle();
  endtask

  task automatic testReset();
    logic [7:0] d;
    busRead(8'hD7, d);
    check("R1 reset register", d, 8'h00);
    pinIn = 5'b10110;
    settle();
    check("R1 reset passthrough", {3'b0, pinOut}, 8'h16);
    pinIn = 5'b0;
    settle();
  endtask

  task automatic testRegister();
    logic [7:0] d;
    busWrite(8'hD7, 8'hFF);
    busRead(8'hD7, d);
    check("R3 upper bits read zero", d, 8'h1F);
    busWrite(8'hD7, 8'h0A);
    busRead(8'hD7, d);
    check("R2 write/read", d, 8'h0A);
    busWrite(8'hD6, 8'h15);
    busRead(8'hD7, d);
    check("R4 foreign write ignored", d, 8'h0A);
    busRead(8'hD8, d);
    check("R4 foreign read zero", d, 8'h00);
    busWrite(8'hD7, 8'hE0);
    busRead(8'hD7, d);
    check("R3 upper-only write", d, 8'h00);
  endtask

  task automatic testPassLatency();
    clearAll();
    @(negedge clk) pinIn = 5'b00001;
    @(negedge clk);
    check("R5 not after edge k", {7'b0, pinOut[0]}, 8'h00);
    @(negedge clk);
    check("R5 not after edge k+1", {7'b0, pinOut[0]}, 8'h00);
    @(negedge clk);
    check("R5 visible after edge k+2", {7'b0, pinOut[0]}, 8'h01);
  endtask

  task automatic testAccept();
    clearAll();
    busWrite(8'hD7, 8'h01);
    pinIn[0] = 1'b1;
    settle();
    check("R8 no tick no change", {7'b0, pinOut[0]}, 8'h00);
    tick(); tick();
    check("R6 two ticks not enough", {7'b0, pinOut[0]}, 8'h00);
    tick();
    check("R6 third tick accepts", {7'b0, pinOut[0]}, 8'h01);
  endtask

  task automatic testGlitch();
    // continues from pin0 enabled, output 1
    pinIn[0] = 1'b0; settle();
    tick(); tick();
    pinIn[0] = 1'b1; settle();
    tick();
    check("R7 short glitch rejected", {7'b0, pinOut[0]}, 8'h01);
    pinIn[0] = 1'b0; settle();
    tick(); tick();
    check("R7 count restarted", {7'b0, pinOut[0]}, 8'h01);
    tick();
    check("R6 accept low", {7'b0, pinOut[0]}, 8'h00);
  endtask

  task automatic testNoTick();
    pinIn[0] = 1'b1;
    repeat (25) @(negedge clk);
    check("R8 long wait without tick", {7'b0, pinOut[0]}, 8'h00);
    tick(); tick(); tick();
    check("R6 accept after wait", {7'b0, pinOut[0]}, 8'h01);
  endtask

  task automatic testStop();
    logic [7:0] d;
    clearAll();
    busWrite(8'hD7, 8'h1F);
    @(negedge clk) stopMode = 1'b1;
    pinIn = 5'b00100;
    settle();
    check("R9 stop bypasses filter", {3'b0, pinOut}, 8'h04);
    @(negedge clk) stopMode = 1'b0;
    pinIn = 5'b00000;
    settle();
    check("R10 filtering restored", {3'b0, pinOut}, 8'h04);
    busRead(8'hD7, d);
    check("R10 enables retained", d, 8'h1F);
    tick(); tick(); tick();
    check("R10 restored filter accepts", {3'b0, pinOut}, 8'h00);
  endtask

  task automatic testIndependent();
    clearAll();
    busWrite(8'hD7, 8'h02);
    pinIn = 5'b01010;
    settle();
    check("R11 unfiltered pin unaffected", {3'b0, pinOut}, 8'h08);
    tick(); tick(); tick();
    check("R11 filtered pin accepts", {3'b0, pinOut}, 8'h0A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegister();
    testPassLatency();
    testAccept();
    testGlitch();
    testNoTick();
    testStop();
    testIndependent();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule